// File: doc/BRIEF.md
# Dual-Mode PIRQ Interrupt Router

This block sits between the level-sensitive interrupt requests of a set of PCI interrupt lanes (PIRQs, eight by default) and the global system interrupt (GSI) vector that feeds the interrupt controllers. The GSI vector has 24 lines. Lines 0 to 15 go to the legacy 8259-style controller, and lines 16 to 23 go to the I/O APIC. Each PIRQ is presented on two paths at once. It always drives its own dedicated APIC line. When its routing byte enables it, it also drives a shared legacy line, and that legacy line is the wired-OR of every lane routed to it.

A single power-management event level (SCI) is merged onto one destination line. That line is chosen by a small select code in a control byte. Reserved codes leave the current destination untouched. When the destination moves while the SCI is high, the old line drops and the new line rises on the same cycle.

Software programs the block through a one-cycle write port. The block also reports, for each PIRQ, the line a consumer should listen to and whether that route is usable. All outputs are registered.

Top module: `pirq_router`

## Requirements
- R1: While synchronous reset is high and on the first cycle after it, `gsi_out` is all zero. Every routing byte takes the value 0x80 (route disabled). The SCI destination is line 9.
- R2: A write with `wr_addr` in 0..7 loads the routing byte of PIRQ number `wr_addr`: bit 7 is the disable flag and bits [4:0] are the legacy IRQ number. A write to address 8 loads the SCI select code from bits [2:0]. Writes to addresses 9..15 change nothing.
- R3: APIC line 16+p equals the level of PIRQ p, whatever its routing byte says, ORed with the SCI when the SCI targets that line.
- R4: Legacy line g (0..15) is the OR of every PIRQ whose routing byte has bit 7 clear and IRQ number g, ORed with the SCI when the SCI targets g.
- R5: A PIRQ whose routing byte is enabled but names an IRQ of 16 or more drives no legacy line.
- R6: SCI select codes 0, 1, 2, 4 and 5 pick lines 9, 10, 11, 20 and 21. Codes 3, 6 and 7 leave the destination unchanged.
- R7: Moving the SCI destination while the SCI is high releases the old line and asserts the new line in the same output cycle.
- R8: The route report for PIRQ p gives: if disabled, valid with line 16+p; if enabled with IRQ below 16, valid with that IRQ; if enabled with IRQ of 16 or more, not valid with line 0.
- R9: `gsi_out` reflects inputs one clock edge after they are sampled. It reflects a register write one edge after the edge that stores the write. The route report follows the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register index: 0..7 routing bytes, 8 SCI control |
| wr_data | input | 8 | Write data |
| pirq_lvl | input | 8 | Level of each PIRQ lane |
| sci_lvl | input | 1 | SCI level |
| gsi_out | output | 24 | Global interrupt lines, 0..15 legacy, 16..23 APIC |
| route_en | output | 8 | Per-PIRQ route usable flag |
| route_line | output | 40 | Per-PIRQ reported line, 5 bits per lane, lane p at [5p+4:5p] |

## Verification
A corrupted routing byte shows at the ports within two edges. The route report moves, and the next active PIRQ lights the wrong legacy line or misses the right one. A stale SCI destination shows on the first cycle the SCI is high, as a lit line other than the one last selected, or as two lit lines after a move. The bench drives directed routing and SCI-move cases and then long pseudo-random traffic. It compares every output on every cycle, so a fault appears on the first cycle it becomes visible.

// File: rtl/pirq_route_pkg.sv
package pirq_route_pkg;

    localparam int GSI_IDX_W = 5;
    localparam logic [7:0] ROUTE_RESET = 8'h80;
    localparam logic [GSI_IDX_W-1:0] SCI_RESET_LINE = 5'd9;

    typedef struct packed {
        logic                 dis;
        logic [1:0]           spare;
        logic [GSI_IDX_W-1:0] irq;
    } route_byte_t;

    typedef struct packed {
        logic                 ok;
        logic [GSI_IDX_W-1:0] line;
    } sci_dest_t;

    typedef struct packed {
        logic                 en;
        logic [GSI_IDX_W-1:0] line;
    } route_rep_t;

    function automatic sci_dest_t sci_code_decode(input logic [2:0] code);
        sci_dest_t d;
        d.ok = 1'b1;
        unique case (code)
            3'd0:    d.line = 5'd9;
            3'd1:    d.line = 5'd10;
            3'd2:    d.line = 5'd11;
            3'd4:    d.line = 5'd20;
            3'd5:    d.line = 5'd21;
            default: begin d.ok = 1'b0; d.line = '0; end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pirq_cfg_regs.sv
module pirq_cfg_regs
    import pirq_route_pkg::*;
#(
    parameter int NUM_PIRQ = 8,
    parameter int ADDR_W   = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [7:0]                    wr_data,
    output route_byte_t [NUM_PIRQ-1:0]    route_q,
    output logic [GSI_IDX_W-1:0]          sci_line_q
);
    localparam int SCI_ADDR = NUM_PIRQ;

    sci_dest_t sci_dec;
    assign sci_dec = sci_code_decode(wr_data[2:0]);

    for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_route
        always_ff @(posedge clk) begin
            if (rst) begin
                route_q[p] <= route_byte_t'(ROUTE_RESET);
            end else if (wr_en && (int'(wr_addr) == p)) begin
                route_q[p]       <= route_byte_t'(wr_data);
                route_q[p].spare <= '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sci_line_q <= SCI_RESET_LINE;
        end else if (wr_en && (int'(wr_addr) == SCI_ADDR) && sci_dec.ok) begin
            sci_line_q <= sci_dec.line;
        end
    end
endmodule

// File: rtl/pirq_gsi_merge.sv
module pirq_gsi_merge
    import pirq_route_pkg::*;
#(
    parameter int NUM_PIRQ   = 8,
    parameter int NUM_LEGACY = 16,
    localparam int NUM_GSI   = NUM_LEGACY + NUM_PIRQ
) (
    input  route_byte_t [NUM_PIRQ-1:0] route_q,
    input  logic [NUM_PIRQ-1:0]        pirq_lvl,
    input  logic                       sci_lvl,
    input  logic [GSI_IDX_W-1:0]       sci_line,
    output logic [NUM_GSI-1:0]         gsi_next
);
    for (genvar g = 0; g < NUM_LEGACY; g++) begin : g_legacy
        always_comb begin
            logic acc;
            acc = sci_lvl && (int'(sci_line) == g);
            for (int p = 0; p < NUM_PIRQ; p++) begin
                if (!route_q[p].dis && (int'(route_q[p].irq) == g))
                    acc = acc | pirq_lvl[p];
            end
            gsi_next[g] = acc;
        end
    end

    for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_apic
        assign gsi_next[NUM_LEGACY+p] = pirq_lvl[p] |
            (sci_lvl && (int'(sci_line) == NUM_LEGACY + p));
    end
endmodule

// File: rtl/pirq_route_report.sv
module pirq_route_report
    import pirq_route_pkg::*;
#(
    parameter int NUM_PIRQ   = 8,
    parameter int NUM_LEGACY = 16
) (
    input  route_byte_t [NUM_PIRQ-1:0] route_q,
    output route_rep_t  [NUM_PIRQ-1:0] rep
);
    for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_rep
        always_comb begin
            if (route_q[p].dis) begin
                rep[p].en   = 1'b1;
                rep[p].line = GSI_IDX_W'(NUM_LEGACY + p);
            end else if (int'(route_q[p].irq) < NUM_LEGACY) begin
                rep[p].en   = 1'b1;
                rep[p].line = route_q[p].irq;
            end else begin
                rep[p].en   = 1'b0;
                rep[p].line = '0;
            end
        end
    end
endmodule

// File: rtl/pirq_router.sv
module pirq_router
    import pirq_route_pkg::*;
#(
    parameter int NUM_PIRQ   = 8,
    parameter int NUM_LEGACY = 16,
    localparam int NUM_GSI   = NUM_LEGACY + NUM_PIRQ,
    localparam int ADDR_W    = $clog2(NUM_PIRQ + 1)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [7:0]                      wr_data,
    input  logic [NUM_PIRQ-1:0]             pirq_lvl,
    input  logic                            sci_lvl,
    output logic [NUM_GSI-1:0]              gsi_out,
    output logic [NUM_PIRQ-1:0]             route_en,
    output logic [NUM_PIRQ*GSI_IDX_W-1:0]   route_line
);
    route_byte_t [NUM_PIRQ-1:0] route_q;
    logic [GSI_IDX_W-1:0]       sci_line_q;
    logic [NUM_GSI-1:0]         gsi_next;
    route_rep_t [NUM_PIRQ-1:0]  rep;

    pirq_cfg_regs #(.NUM_PIRQ(NUM_PIRQ), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .route_q(route_q), .sci_line_q(sci_line_q)
    );

    pirq_gsi_merge #(.NUM_PIRQ(NUM_PIRQ), .NUM_LEGACY(NUM_LEGACY)) u_merge (
        .route_q(route_q), .pirq_lvl(pirq_lvl), .sci_lvl(sci_lvl),
        .sci_line(sci_line_q), .gsi_next(gsi_next)
    );

    pirq_route_report #(.NUM_PIRQ(NUM_PIRQ), .NUM_LEGACY(NUM_LEGACY)) u_rep (
        .route_q(route_q), .rep(rep)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gsi_out <= '0;
        end else begin
            gsi_out <= gsi_next;
        end
    end

    for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_out
        always_ff @(posedge clk) begin
            if (rst) begin
                route_en[p]                         <= 1'b1;
                route_line[p*GSI_IDX_W +: GSI_IDX_W] <= GSI_IDX_W'(NUM_LEGACY + p);
            end else begin
                route_en[p]                         <= rep[p].en;
                route_line[p*GSI_IDX_W +: GSI_IDX_W] <= rep[p].line;
            end
        end
    end
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk
    import pirq_route_pkg::*;
#(
    parameter int NUM_PIRQ   = 8,
    parameter int NUM_LEGACY = 16,
    localparam int NUM_GSI   = NUM_LEGACY + NUM_PIRQ
) (
    input logic                          clk,
    input logic                          rst,
    input logic [NUM_PIRQ-1:0]           pirq_lvl,
    input logic                          sci_lvl,
    input logic [NUM_GSI-1:0]            gsi_out,
    input logic [NUM_PIRQ-1:0]           route_en,
    input logic [NUM_PIRQ*GSI_IDX_W-1:0] route_line
);
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // R1: output register cleared on the cycle after reset
    p_reset_clear_r1: assert property (@(posedge clk) rst |=> (gsi_out == '0));

    for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_lane
        // R3: an active lane always reaches its own APIC line
        p_apic_follow_r3: assert property (@(posedge clk) disable iff (rst || !armed)
            $past(pirq_lvl[p]) |-> gsi_out[NUM_LEGACY+p]);
        // R8: an unusable route reports line 0
        p_report_zero_r8: assert property (@(posedge clk) disable iff (rst)
            !route_en[p] |-> (route_line[p*GSI_IDX_W +: GSI_IDX_W] == '0));
        // R8: a reported APIC line is the lane's own
        p_report_apic_r8: assert property (@(posedge clk) disable iff (rst)
            (route_en[p] && int'(route_line[p*GSI_IDX_W +: GSI_IDX_W]) >= NUM_LEGACY)
            |-> (int'(route_line[p*GSI_IDX_W +: GSI_IDX_W]) == NUM_LEGACY + p));
    end

    // R4: no legacy line without a source
    p_legacy_source_r4: assert property (@(posedge clk) disable iff (rst || !armed)
        (|gsi_out[NUM_LEGACY-1:0]) |-> ($past(|pirq_lvl) || $past(sci_lvl)));

    // R7: SCI alone lights exactly one line
    p_sci_single_r7: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(pirq_lvl) == '0 && $past(sci_lvl)) |-> ($countones(gsi_out) == 1));

    // R9: quiet inputs give quiet outputs one edge later
    p_quiet_r9: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(pirq_lvl) == '0 && !$past(sci_lvl)) |-> (gsi_out == '0));
endmodule

bind pirq_router pirq_router_chk #(.NUM_PIRQ(NUM_PIRQ), .NUM_LEGACY(NUM_LEGACY)) u_chk (
    .clk(clk), .rst(rst), .pirq_lvl(pirq_lvl), .sci_lvl(sci_lvl),
    .gsi_out(gsi_out), .route_en(route_en), .route_line(route_line)
);

// File: tb/pirq_router_bench.sv
`timescale 1ns/100ps
module pirq_router_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  pirq_lvl = '0;
    logic        sci_lvl = 1'b0;
    logic [23:0] gsi_out;
    logic [7:0]  route_en;
    logic [39:0] route_line;

    pirq_router u_pirq_router (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pirq_lvl(pirq_lvl), .sci_lvl(sci_lvl), .gsi_out(gsi_out),
        .route_en(route_en), .route_line(route_line)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string cur_req = "R1";

    int m_rt [8];
    int m_sci;
    logic [23:0] e_gsi;
    logic [7:0]  e_en;
    logic [39:0] e_line;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic model_expect(input bit r, input logic [7:0] pl, input bit sl);
        e_gsi = '0; e_en = '0; e_line = '0;
        for (int p = 0; p < 8; p++) begin
            int dis = (m_rt[p] >> 7) & 1;
            int irq = m_rt[p] & 31;
            if (r) begin
                e_en[p] = 1'b1; e_line[p*5 +: 5] = 5'(16 + p);
            end else begin
                if (pl[p]) e_gsi[16+p] = 1'b1;
                if (dis == 0 && irq < 16 && pl[p]) e_gsi[irq] = 1'b1;
                if (dis == 1)      begin e_en[p] = 1'b1; e_line[p*5 +: 5] = 5'(16 + p); end
                else if (irq < 16) begin e_en[p] = 1'b1; e_line[p*5 +: 5] = 5'(irq); end
            end
        end
        if (!r && sl) e_gsi[m_sci] = 1'b1;
    endtask

    task automatic model_write(input bit r, input bit we, input int addr, input int data);
        if (r) begin
            for (int p = 0; p < 8; p++) m_rt[p] = 'h80;
            m_sci = 9;
        end else if (we) begin
            if (addr < 8) m_rt[addr] = data & 'h9F;
            else if (addr == 8) begin
                case (data & 7)
                    0: m_sci = 9;
                    1: m_sci = 10;
                    2: m_sci = 11;
                    4: m_sci = 20;
                    5: m_sci = 21;
                    default: ;
                endcase
            end
        end
    endtask

    task automatic step(input bit r, input bit we, input int addr, input int data,
                        input logic [7:0] pl, input bit sl);
        rst = r; wr_en = we; wr_addr = addr[3:0]; wr_data = data[7:0];
        pirq_lvl = pl; sci_lvl = sl;
        model_expect(r, pl, sl);
        model_write(r, we, addr, data);
        @(posedge clk);
        #1;
        checks++;
        if (gsi_out !== e_gsi) begin
            fails++;
            $display("FAIL %s gsi_out actual %h expected %h", cur_req, gsi_out, e_gsi);
        end
        checks++;
        if (route_en !== e_en || route_line !== e_line) begin
            fails++;
            $display("FAIL %s route actual en=%h line=%h expected en=%h line=%h",
                     cur_req, route_en, route_line, e_en, e_line);
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n, input logic [7:0] pl, input bit sl);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 0, 0, pl, sl);
    endtask

    initial begin
        int lfsr = 32'h1ACE5EED;
        m_sci = 9;
        for (int p = 0; p < 8; p++) m_rt[p] = 'h80;
        @(negedge clk);
        cur_req = "R1";
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 0, 0, 8'hFF, 1'b1);
        idle(2, 8'h00, 1'b0);

        cur_req = "R3";
        idle(1, 8'h01, 1'b0); idle(1, 8'hA5, 1'b0); idle(1, 8'hFF, 1'b0);

        cur_req = "R2";
        step(1'b0, 1'b1, 0, 'h05, 8'h00, 1'b0);
        step(1'b0, 1'b1, 1, 'h65, 8'h00, 1'b0);
        step(1'b0, 1'b1, 2, 'h0A, 8'h00, 1'b0);
        idle(2, 8'h00, 1'b0);

        cur_req = "R4";
        idle(1, 8'h01, 1'b0); idle(1, 8'h02, 1'b0); idle(1, 8'h03, 1'b0);
        idle(1, 8'h04, 1'b0); idle(1, 8'h00, 1'b0);

        cur_req = "R5";
        step(1'b0, 1'b1, 3, 'h14, 8'h08, 1'b0);
        idle(2, 8'h08, 1'b0);
        step(1'b0, 1'b1, 3, 'h1F, 8'h08, 1'b0);
        idle(2, 8'h0F, 1'b0);

        cur_req = "R6";
        idle(2, 8'h00, 1'b1);
        step(1'b0, 1'b1, 8, 'h03, 8'h00, 1'b1);
        idle(2, 8'h00, 1'b1);
        step(1'b0, 1'b1, 8, 'h02, 8'h00, 1'b1);
        idle(2, 8'h00, 1'b1);
        step(1'b0, 1'b1, 8, 'hF7, 8'h00, 1'b1);
        idle(2, 8'h00, 1'b1);

        cur_req = "R7";
        step(1'b0, 1'b1, 8, 'h01, 8'h00, 1'b1);
        idle(2, 8'h00, 1'b1);
        step(1'b0, 1'b1, 8, 'h04, 8'h00, 1'b1);
        idle(2, 8'h10, 1'b1);
        step(1'b0, 1'b1, 8, 'h05, 8'h00, 1'b1);
        idle(2, 8'h00, 1'b1);
        idle(1, 8'h00, 1'b0);

        cur_req = "R2";
        for (int a = 9; a < 16; a++) step(1'b0, 1'b1, a, 'h00, 8'h00, 1'b0);
        idle(2, 8'hFF, 1'b1);

        cur_req = "R8";
        step(1'b0, 1'b1, 7, 'h10, 8'h00, 1'b0);
        step(1'b0, 1'b1, 6, 'h8F, 8'h00, 1'b0);
        idle(2, 8'hC0, 1'b0);

        cur_req = "R9";
        for (int i = 0; i < 3000; i++) begin
            int op;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            op = lfsr & 15;
            step(1'b0, op < 5, (lfsr >> 4) % 16, (lfsr >> 8) & 'hFF,
                 8'(lfsr >> 16), lfsr[27]);
        end

        cur_req = "R1";
        step(1'b1, 1'b0, 0, 0, 8'hFF, 1'b1);
        idle(3, 8'hFF, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule